// File: doc/BRIEF.md
# Edge-Selectable Diagnostic Interrupt Controller

This block merges eleven asynchronous diagnostic flags from a radio subsystem into a single interrupt line. Each flag is first brought into the local clock domain. Its edges are then watched, and a chosen edge latches a pending bit. A pending bit raises the interrupt only when its enable bit is set.

Software reaches the block through a plain register port. It has a two-bit word address, a write strobe, write data and combinational read data. Through this port software can:
- read the synchronized live levels;
- choose, for each of the lower eight flags, whether a rising or a falling edge counts;
- inspect pending events and acknowledge them by writing ones;
- enable or disable each source's contribution to the interrupt.

The three upper flags have no polarity choice and always count rising edges.

Top module: `diag_irq_ctrl`

## Requirements
- R1: While reset is low at a clock edge, every register (polarity, pending, enable and the synchronizer stages) returns to zero and `irq_o` is low after that edge.
- R2: Word address 0 reads the synchronized live levels in bits 10:0, with zero above them. A level applied to `diag_in` before clock edge k is visible after edge k+1. Writes to address 0 have no effect.
- R3: Word address 1 holds the polarity bits 7:0. A bit value of 0 selects the rising edge and 1 selects the falling edge. A write stores `reg_wdata[7:0]`, and bits 31:8 always read zero.
- R4: Sources 8, 9 and 10 set their pending bit only on a rising edge, whatever was written to address 1.
- R5: Word address 2 reads the pending bits 10:0. A selected edge on `diag_in` applied before edge k sets its pending bit after edge k+2.
- R6: A write to address 2 clears each pending bit whose `reg_wdata` bit is 1. Bits written as 0 are left unchanged.
- R7: If a new edge and a clearing write reach the same pending bit at the same clock edge, the bit stays set.
- R8: Word address 3 holds the enable bits 10:0. A write stores `reg_wdata[10:0]`, and bits above 10 read zero.
- R9: `irq_o` is registered. After each clock edge it is high exactly when, before that edge, some pending bit had its enable bit set.
- R10: Changing a polarity bit while its source is steady does not set a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| diag_in | input | 11 | Asynchronous diagnostic flags |
| reg_addr | input | 2 | Register word select (0 level, 1 polarity, 2 pending, 3 enable) |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `diag_in`, `reg_addr`, `reg_wen` and `reg_wdata` change only away from the rising clock edge. They also assume that the level check on address 0 counts from the second cycle after reset, once both synchronizer stages hold real input samples. The bench meets these assumptions by driving every input on the falling edge and holding it through the next rising edge. It also starts comparing only after the first reset edge. The flags change as whole-cycle levels, so each transition the edge logic sees is one the reference model sees too.

// File: rtl/diag_irq_pkg.sv
// Package: shared register selector encoding for the diagnostic interrupt controller.
// Assumes a two-bit word address on the register port.
package diag_irq_pkg;

    typedef enum logic [1:0] {
        REG_LEVEL = 2'd0,
        REG_POL   = 2'd1,
        REG_PEND  = 2'd2,
        REG_ENA   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/diag_sync.sv
// Module: per-bit two-stage synchronizer for asynchronous level inputs.
// Assumes each input stays at a level long enough for the receiving clock to see it.
module diag_sync #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Two flops per bit, cleared by the synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                stab_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= async_i[i];
                stab_q[i] <= meta_q[i];
            end
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/diag_edge_det.sv
// Module: per-source edge detector with an optional polarity select.
// Sources below POL_SRC use their polarity bit (0 rising, 1 falling); the rest detect rising only.
// Assumes lvl_i is already synchronous. The event depends only on a level transition,
// so a change of polarity on a steady source produces no event.
module diag_edge_det #(
    parameter int NUM_SRC = 11,
    parameter int POL_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [POL_SRC-1:0] pol_i,
    output logic [NUM_SRC-1:0] evt_o
);

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;

    // Hold the previous synchronized level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < POL_SRC) begin : g_sel
            assign evt_o[i] = pol_i[i] ? fall[i] : rise[i];
        end else begin : g_fixed
            assign evt_o[i] = rise[i];
        end
    end

endmodule

// File: rtl/diag_irq_regs.sv
// Module: polarity, pending and enable registers, the read mux and the registered interrupt.
// Assumes evt_i is a single-cycle event vector; a set from evt_i wins over a clear in the same cycle.
module diag_irq_regs
    import diag_irq_pkg::*;
#(
    parameter int NUM_SRC = 11,
    parameter int POL_SRC = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         addr_i,
    input  logic               wen_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [POL_SRC-1:0] pol_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    logic [POL_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] ena_q;
    logic               irq_q;
    logic               wr_pol;
    logic               wr_pend;
    logic               wr_ena;
    logic [NUM_SRC-1:0] clr_bits;
    reg_sel_e           sel;

    assign sel      = reg_sel_e'(addr_i);
    assign wr_pol   = wen_i && (sel == REG_POL);
    assign wr_pend  = wen_i && (sel == REG_PEND);
    assign wr_ena   = wen_i && (sel == REG_ENA);
    assign clr_bits = wr_pend ? wdata_i : '0;

    // Polarity register, lower sources only
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_q <= '0;
        else if (wr_pol) pol_q <= wdata_i[POL_SRC-1:0];
    end

    // Pending bits: write-one-to-clear, new event has priority
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | evt_i;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      ena_q <= '0;
        else if (wr_ena) ena_q <= wdata_i;
    end

    // Registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_q & ena_q);
    end

    // Read mux, zero-extended fields
    always_comb begin
        rdata_o = '0;
        case (sel)
            REG_LEVEL: rdata_o[NUM_SRC-1:0] = lvl_i;
            REG_POL:   rdata_o[POL_SRC-1:0] = pol_q;
            REG_PEND:  rdata_o[NUM_SRC-1:0] = pend_q;
            REG_ENA:   rdata_o[NUM_SRC-1:0] = ena_q;
            default:   rdata_o = '0;
        endcase
    end

    assign pol_o  = pol_q;
    assign pend_o = pend_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/diag_irq_ctrl.sv
// Module: top of the diagnostic interrupt controller.
// Chains the synchronizer, the edge detector and the register bank.
// Assumes register port inputs are synchronous to clk; diag_in may be asynchronous.
module diag_irq_ctrl #(
    parameter int NUM_SRC = 11,
    parameter int POL_SRC = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] diag_in,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wen,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] lvl_sync;
    logic [NUM_SRC-1:0] edge_evt;
    logic [NUM_SRC-1:0] pend_bits;
    logic [POL_SRC-1:0] pol_bits;

    diag_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (diag_in),
        .sync_o  (lvl_sync)
    );

    diag_edge_det #(.NUM_SRC(NUM_SRC), .POL_SRC(POL_SRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl_sync),
        .pol_i (pol_bits),
        .evt_o (edge_evt)
    );

    diag_irq_regs #(.NUM_SRC(NUM_SRC), .POL_SRC(POL_SRC), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wen_i   (reg_wen),
        .wdata_i (reg_wdata),
        .lvl_i   (lvl_sync),
        .evt_i   (edge_evt),
        .pol_o   (pol_bits),
        .pend_o  (pend_bits),
        .rdata_o (reg_rdata),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/diag_irq_chk.sv
// Module: assertion checker for diag_irq_ctrl, attached by bind.
// Assumes inputs change away from the rising clock edge.
module diag_irq_chk #(
    parameter int NUM_SRC = 11,
    parameter int POL_SRC = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] diag_in,
    input logic [1:0]         reg_addr,
    input logic               reg_wen,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] lvl,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] pend
);

    logic [1:0] since_rst;

    // Cycles since reset, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    a_r2_level_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && reg_addr == 2'd0) |-> (reg_rdata[NUM_SRC-1:0] == $past(diag_in, 2)));

    a_r3_pol_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[DATA_W-1:POL_SRC] == '0));

    a_r4_upper_rising: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt[NUM_SRC-1:POL_SRC] & ~lvl[NUM_SRC-1:POL_SRC]) == '0));

    a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt) && !(reg_wen && reg_addr == 2'd2)) |=> $stable(pend));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 2'd2 && !(|evt)) |=> ((pend & $past(reg_wdata)) == '0));

    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> !irq_o);

endmodule

bind diag_irq_ctrl diag_irq_chk #(.NUM_SRC(NUM_SRC), .POL_SRC(POL_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .diag_in   (diag_in),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .lvl       (lvl_sync),
    .evt       (edge_evt),
    .pend      (pend_bits)
);

// File: tb/sim_diag_irq_ctrl.sv
// Bench: behavioural reference model compared against the design on every clock.
module sim_diag_irq_ctrl;

    localparam int NS = 11;
    localparam int NP = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] diag;
    logic [1:0]    addr;
    logic          wen;
    logic [NS-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          irq;

    always #5 clk = ~clk;

    diag_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .diag_in   (diag),
        .reg_addr  (addr),
        .reg_wen   (wen),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state: input history (newest first), registers, interrupt
    logic [NS-1:0] hist[$];
    logic [NP-1:0] m_pol;
    logic [NS-1:0] m_pend;
    logic [NS-1:0] m_ena;
    logic          m_irq;

    function automatic void m_reset();
        hist = {};
        repeat (3) hist.push_back('0);
        m_pol  = '0;
        m_pend = '0;
        m_ena  = '0;
        m_irq  = 1'b0;
    endfunction

    function automatic void m_clock();
        logic [NS-1:0] now  = hist[1];
        logic [NS-1:0] old  = hist[2];
        logic [NS-1:0] ev   = '0;
        logic [NS-1:0] clr  = '0;
        for (int i = 0; i < NS; i++) begin
            if (i < NP && m_pol[i]) ev[i] = old[i] && !now[i];
            else                    ev[i] = now[i] && !old[i];
        end
        if (wen && addr == 2'd2) clr = wdata;
        m_irq  = |(m_pend & m_ena);
        m_pend = (m_pend & ~clr) | ev;
        if (wen && addr == 2'd1) m_pol = wdata[NP-1:0];
        if (wen && addr == 2'd3) m_ena = wdata;
        hist.push_front(diag);
        void'(hist.pop_back());
    endfunction

    task automatic check(input string tag);
        logic [DW-1:0] exp_rd = '0;
        string req;
        case (addr)
            2'd0: begin exp_rd[NS-1:0] = hist[1]; req = "R2"; end
            2'd1: begin exp_rd[NP-1:0] = m_pol;   req = "R3"; end
            2'd2: begin exp_rd[NS-1:0] = m_pend;  req = "R5"; end
            default: begin exp_rd[NS-1:0] = m_ena; req = "R8"; end
        endcase
        n_cmp++;
        if (rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s [%s] rdata addr %0d: actual %h expected %h", req, tag, addr, rdata, exp_rd);
        end
        n_cmp++;
        if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL R9 [%s] irq: actual %b expected %b", tag, irq, m_irq);
        end
    endtask

    task automatic step(input logic [NS-1:0] d, input logic [1:0] a, input logic w,
                        input logic [NS-1:0] wd, input string tag);
        @(negedge clk);
        diag = d; addr = a; wen = w; wdata = wd;
        #1 check(tag);
        @(posedge clk);
        if (!rst_n) m_reset();
        else        m_clock();
    endtask

    // Hold inputs and read one address
    task automatic rd(input logic [NS-1:0] d, input logic [1:0] a, input string tag);
        step(d, a, 1'b0, '0, tag);
    endtask

    initial begin
        rst_n = 1'b0; diag = '0; addr = '0; wen = 1'b0; wdata = '0;
        @(posedge clk);
        m_reset();
        // R1: reset state of every register and irq
        for (int a = 0; a < 4; a++) rd('0, 2'(a), "R1");
        step('0, 2'd3, 1'b1, '1, "R1");
        rd('0, 2'd3, "R1");
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) rd('0, 2'(a), "R1");

        // R2: live levels, two-edge delay, writes to address 0 ignored
        step(11'h5A5, 2'd0, 1'b1, '1, "R2");
        rd(11'h5A5, 2'd0, "R2");
        rd(11'h0F0, 2'd0, "R2");
        step(11'h0F0, 2'd0, 1'b1, 11'h123, "R2");
        rd(11'h7FF, 2'd0, "R2");
        rd(11'h000, 2'd0, "R2");
        rd(11'h000, 2'd0, "R2");
        step('0, 2'd2, 1'b1, '1, "R6");

        // R3: polarity register width and readback
        step('0, 2'd1, 1'b1, 11'h7FF, "R3");
        rd('0, 2'd1, "R3");

        // R4: all polarity bits falling; upper sources still rise-only
        rd(11'h700, 2'd2, "R4");
        rd(11'h700, 2'd2, "R4");
        rd(11'h700, 2'd2, "R4");
        rd(11'h000, 2'd2, "R4");
        rd(11'h000, 2'd2, "R4");
        rd(11'h000, 2'd2, "R4");
        rd(11'h0FF, 2'd2, "R4");
        rd(11'h0FF, 2'd2, "R4");
        rd(11'h0FF, 2'd2, "R4");
        rd(11'h000, 2'd2, "R4");
        rd(11'h000, 2'd2, "R4");
        rd(11'h000, 2'd2, "R4");

        // R6: write-one clears, zero bits untouched
        step('0, 2'd2, 1'b1, 11'h0F0, "R6");
        rd('0, 2'd2, "R6");
        step('0, 2'd2, 1'b1, 11'h000, "R6");
        step('0, 2'd2, 1'b1, '1, "R6");
        rd('0, 2'd2, "R6");

        // R5: rising polarity, pending timing
        step('0, 2'd1, 1'b1, 11'h000, "R5");
        rd(11'h013, 2'd2, "R5");
        rd(11'h013, 2'd2, "R5");
        rd(11'h013, 2'd2, "R5");
        rd(11'h013, 2'd2, "R5");

        // R8, R9: enables gate the interrupt
        step(11'h013, 2'd3, 1'b1, 11'h004, "R8");
        rd(11'h013, 2'd3, "R9");
        rd(11'h013, 2'd3, "R9");
        step(11'h013, 2'd3, 1'b1, 11'h002, "R8");
        rd(11'h013, 2'd3, "R9");
        rd(11'h013, 2'd3, "R9");
        step(11'h013, 2'd2, 1'b1, 11'h002, "R9");
        rd(11'h013, 2'd2, "R9");
        rd(11'h013, 2'd2, "R9");
        step(11'h013, 2'd2, 1'b1, '1, "R6");

        // R7: set and clear collide on bit 0
        rd(11'h012, 2'd2, "R7");
        rd(11'h012, 2'd2, "R7");
        rd(11'h013, 2'd2, "R7");
        rd(11'h013, 2'd2, "R7");
        step(11'h013, 2'd2, 1'b1, 11'h001, "R7");
        rd(11'h013, 2'd2, "R7");
        step(11'h013, 2'd2, 1'b1, '1, "R6");
        rd(11'h013, 2'd2, "R7");

        // R10: polarity flips on steady sources
        for (int k = 0; k < 4; k++) begin
            step(11'h013, 2'd1, 1'b1, (k % 2 == 0) ? 11'h0FF : 11'h000, "R10");
            rd(11'h013, 2'd2, "R10");
            rd(11'h013, 2'd2, "R10");
        end

        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [NS-1:0] d = diag;
            if ($urandom_range(0, 3) == 0) d[$urandom_range(0, NS - 1)] ^= 1'b1;
            step(d, 2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 3),
                 NS'($urandom), "MIX");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule